// File: doc/BRIEF.md
# Grace-Period Fatal Escalation Timer

This block merges two summary fault flags into one latched reset-request line. The first flag says that some serious (ERROR-class) fault is pending. The second says that some unrecoverable (FATAL-class) fault is pending. FATAL faults drive the reset request at once. ERROR faults first start a programmable countdown. Software can withdraw the request during that time by clearing every ERROR-class fault. If the countdown ends while the fault is still pending, the request latches. It stays high until the ERROR condition is gone.

The reload value comes from a configuration register outside the block and is sampled only when a countdown starts. A reload of zero gives no window at all, so ERROR then escalates as quickly as the state machine allows. A two-bit status output reports whether the countdown is running and whether the reset request is high. The logic that reduces individual pending bits to the two flags is not part of this block, and neither is bus access to the reload register.

Top module: `grace_escalation_timer`

## Requirements
- R1: Out of reset, `cnt_active_o` and `err_sig_o` are low and `status_o` is 2'b00.
- R2: When `err_any_i` is sampled high at a clock edge while the block is idle and `reload_i` is N > 0, the countdown starts and `cnt_active_o` is high after that edge.
- R3: If `err_any_i` stays high, `err_sig_o` rises after the N-th rising edge that follows the starting edge. At the same edge `cnt_active_o` falls.
- R4: Once raised by expiry, `err_sig_o` stays high for as long as `err_any_i` stays high. After the first edge at which `err_any_i` is sampled low, it drops, unless a FATAL flag holds it high.
- R5: If `err_any_i` is sampled low while the countdown runs, the countdown stops at that edge, `cnt_active_o` falls, and that event never raises `err_sig_o`.
- R6: With `reload_i` = 0, an ERROR start raises `err_sig_o` after the starting edge itself, and `cnt_active_o` never goes high.
- R7: `fatal_any_i` high drives `err_sig_o` high in the same cycle, with no clock edge needed. It has no effect on the countdown or on `cnt_active_o`.
- R8: While the countdown runs, `err_any_i` staying high does not restart it, and a change on `reload_i` does not alter its length.
- R9: After the expired latch clears, the next time `err_any_i` is sampled high a fresh countdown starts with the current `reload_i`.
- R10: `status_o[0]` equals `cnt_active_o` and `status_o[1]` equals `err_sig_o` in every cycle.
- R11: The countdown width is the parameter `CNT_W` (1 to 32, default 24), so the largest reload is 2^CNT_W - 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_any_i | input | 1 | At least one ERROR-class fault pending |
| fatal_any_i | input | 1 | At least one FATAL-class fault pending |
| reload_i | input | CNT_W | Grace period in cycles, sampled when a countdown starts |
| err_sig_o | output | 1 | Reset request |
| cnt_active_o | output | 1 | Countdown running |
| status_o | output | 2 | Bit 0 countdown running, bit 1 reset request |

## Verification
The bench builds the block with `CNT_W` = 4, so the all-ones reload of 15 cycles can be run to expiry in a short test. Aborts are tried one cycle before expiry and on the very first counting cycle. Fatal pulses are applied during a countdown, during a latched request and while the block is idle. A reload change during a countdown, a zero reload and re-arming straight after a latch clears are also covered. Every cycle is compared with a behavioural reference.

// File: rtl/egt_pkg.sv
package egt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_EXPIRED = 2'd2
  } egt_state_e;
endpackage

// File: rtl/egt_downcount.sv
module egt_downcount #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);
  assign cnt_o  = cnt_q;

  // R8: a running count only steps down by one
  a_r8_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && !clr_i) |=> (cnt_o == $past(cnt_o) - ONE));

  // R2: a load takes the sampled value
  a_r2_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_o == $past(val_i)));
endmodule

// File: rtl/egt_fsm.sv
module egt_fsm
  import egt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic zero_reload_i,
  input  logic last_i,
  output logic load_o,
  output logic dec_o,
  output logic clr_o,
  output logic run_o,
  output logic expired_o
);
  egt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (err_i) begin
          if (zero_reload_i) state_d = ST_EXPIRED;
          else begin
            load_o  = 1'b1;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (!err_i) begin
          clr_o   = 1'b1;
          state_d = ST_IDLE;
        end else if (last_i) begin
          clr_o   = 1'b1;
          state_d = ST_EXPIRED;
        end else begin
          dec_o = 1'b1;
        end
      end
      ST_EXPIRED: begin
        if (!err_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o     = (state_q == ST_RUN);
  assign expired_o = (state_q == ST_EXPIRED);

  // R5: losing the ERROR flag mid-count aborts without expiry
  a_r5_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !err_i) |=> (!run_o && !expired_o));

  // R4: expiry holds while the ERROR flag persists
  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && err_i) |=> expired_o);

  // R4: expiry releases once the ERROR flag drops
  a_r4_latch_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !err_i) |=> !expired_o);

  // R6: zero reload skips the countdown
  a_r6_zero_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !expired_o && err_i && zero_reload_i) |=> (expired_o && !run_o));

  a_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({run_o, expired_o}));
endmodule

// File: rtl/grace_escalation_timer.sv
module grace_escalation_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_any_i,
  input  logic             fatal_any_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             err_sig_o,
  output logic             cnt_active_o,
  output logic [1:0]       status_o
);
  localparam int unsigned STATUS_ACTIVE = 0;
  localparam int unsigned STATUS_ERR    = 1;

  logic load, dec, clr, last, run, expired;
  logic [CNT_W-1:0] cnt;

  egt_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .err_i         (err_any_i),
    .zero_reload_i (reload_i == '0),
    .last_i        (last),
    .load_o        (load),
    .dec_o         (dec),
    .clr_o         (clr),
    .run_o         (run),
    .expired_o     (expired)
  );

  egt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (reload_i),
    .dec_i  (dec),
    .clr_i  (clr),
    .last_o (last),
    .cnt_o  (cnt)
  );

  // fatal path is combinational: no edge between flag and request
  assign err_sig_o                = expired | fatal_any_i;
  assign cnt_active_o             = run;
  assign status_o[STATUS_ACTIVE]  = run;
  assign status_o[STATUS_ERR]     = err_sig_o;

  // R3: the final count step arms the latched request
  a_r3_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_active_o && err_any_i && last) |=> (err_sig_o && !cnt_active_o));

  // R7: a fatal flag always reaches the request
  a_r7_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_any_i |-> err_sig_o);

  // R8: a running count never restarts from the reload value
  a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_active_o && err_any_i && !last) |=> (cnt_active_o && cnt != $past(reload_i) || cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: tb/grace_escalation_timer_tb.sv
module grace_escalation_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             err_any = 1'b0;
  logic             fatal_any = 1'b0;
  logic [CNT_W-1:0] reload = '0;
  logic             err_sig, cnt_active;
  logic [1:0]       status;

  int n_vec = 0;
  int n_bad = 0;

  // reference state
  int  m_rem = 0;
  bit  m_run = 0;
  bit  m_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grace_escalation_timer #(.CNT_W(CNT_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .err_any_i    (err_any),
    .fatal_any_i  (fatal_any),
    .reload_i     (reload),
    .err_sig_o    (err_sig),
    .cnt_active_o (cnt_active),
    .status_o     (status)
  );

  task automatic compare(input string tag);
    bit   e_sig = m_exp | fatal_any;
    bit   e_act = m_run;
    n_vec++;
    if (err_sig !== e_sig || cnt_active !== e_act || status !== {e_sig, e_act}) begin
      n_bad++;
      $display("FAIL %s t=%0t sig/act/status=%b/%b/%b expected %b/%b/%b",
               tag, $time, err_sig, cnt_active, status, e_sig, e_act, {e_sig, e_act});
    end
  endtask

  task automatic model_edge();
    if (m_run) begin
      if (!err_any) m_run = 0;
      else if (m_rem == 1) begin m_run = 0; m_exp = 1; end
      else m_rem = m_rem - 1;
    end else if (m_exp) begin
      if (!err_any) m_exp = 0;
    end else if (err_any) begin
      if (reload == 0) m_exp = 1;
      else begin m_run = 1; m_rem = int'(reload); end
    end
  endtask

  // drive, compare combinational result, clock, return at negedge
  task automatic step(input bit e, input bit f, input int rl, input string tag);
    err_any   = e;
    fatal_any = f;
    reload    = CNT_W'(rl);
    #1;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    step(0, 0, 3, "R1");

    // R2 R3 R4 R10: reload 3 held to expiry, then release
    step(1, 0, 3, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 3, "R3");
    for (int i = 0; i < 3; i++) step(1, 0, 3, "R4");
    step(0, 0, 3, "R4");
    step(0, 0, 3, "R10");

    // R5: abort one cycle before expiry
    step(1, 0, 4, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 4, "R5");
    step(0, 0, 4, "R5");
    for (int i = 0; i < 5; i++) step(0, 0, 4, "R5");

    // R5: abort on first counting cycle
    step(1, 0, 5, "R5");
    step(0, 0, 5, "R5");
    step(0, 0, 5, "R5");

    // R6: zero reload
    step(1, 0, 0, "R6");
    step(1, 0, 0, "R6");
    step(1, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(0, 0, 0, "R6");

    // R7: fatal while idle, during count and while latched
    step(0, 1, 2, "R7");
    step(0, 0, 2, "R7");
    step(1, 0, 6, "R7");
    step(1, 1, 6, "R7");
    step(1, 1, 6, "R7");
    step(1, 0, 6, "R7");
    for (int i = 0; i < 4; i++) step(1, 0, 6, "R7");
    step(1, 1, 6, "R7");
    step(0, 1, 6, "R7");
    step(0, 0, 6, "R7");

    // R8: reload changes mid-count are ignored
    step(1, 0, 3, "R8");
    step(1, 0, 9, "R8");
    step(1, 0, 1, "R8");
    step(1, 0, 0, "R8");
    step(1, 0, 12, "R8");
    step(0, 0, 3, "R8");

    // R9: re-arm immediately after latch clears
    step(1, 0, 2, "R9");
    step(1, 0, 2, "R9");
    step(1, 0, 2, "R9");
    step(0, 0, 2, "R9");
    step(1, 0, 1, "R9");
    step(1, 0, 1, "R9");
    step(1, 0, 1, "R9");
    step(0, 0, 1, "R9");

    // R11: full-width reload
    step(1, 0, 15, "R11");
    for (int i = 0; i < 17; i++) step(1, 0, 15, "R11");
    step(0, 0, 15, "R11");
    step(0, 0, 15, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule